// File: doc/BRIEF.md
# Attribute-Driven Tilemap Video Generator

This block turns two small screen memories into a stream of indexed colour pixels for a 256 by 256 visible raster. The screen is a grid of 32 by 32 character cells, each 8 by 8 pixels and scanned row by row. For every cell a code byte and an attribute byte are held in two 1 KB RAMs that share one cell index. The attribute widens the code to 9 bits, picks one of two graphics banks and supplies a 4-bit colour group. The block then reads three plane bytes for the current row of the cell from external graphics storage. It shifts the pixels out and looks each one up in an external 256-entry colour PROM to drive single-bit red, green and blue.

A host processor fills both RAMs through a simple write port. The raster runs from a horizontal and vertical counter pair on the pixel clock. The block also produces sync windows, a display-enable flag and a one-cycle vertical-blank pulse that is meant for the processor's non-maskable interrupt. The next cell's data is fetched while the last pixel of the current cell is on screen, so the pixel stream has no gaps.

Top module: `tile_video_gen`

## Requirements
- R1: The raster counts H_TOTAL pixels per line and V_TOTAL lines per frame. `de` is high exactly for pixels with x below 256 and y below 256. All outputs are registered and show the pixel one clock after the counter reaches it.
- R2: A write with `cpu_we` high stores `cpu_wdata` into the code RAM when `cpu_addr` is in 0x1000..0x13FF, at index address minus 0x1000. It stores into the attribute RAM when the address is in 0x1800..0x1BFF, at index address minus 0x1800. Writes to any other address change nothing on screen.
- R3: The cell index for pixel (x,y) is (y/8)*32 + x/8. The graphics address is {attribute bit 1, attribute bit 0, code byte, y mod 8}, which is 13 bits. Attribute bit 0 is therefore the MSB of the 9-bit tile code.
- R4: Attribute bit 1 selects the graphics bank and is the top bit of `gfx_addr`.
- R5: Attribute bits 7:6 have no effect on any output.
- R6: `gfx_data[23:16]` supplies pixel bit 2, `[15:8]` supplies bit 1 and `[7:0]` supplies bit 0. Pixel column k of a cell (k=0 leftmost) takes bit 7-k of each byte.
- R7: The palette address is {0, attribute bits 5:2, 3-bit pixel}, so the upper half of the PROM is never addressed.
- R8: Red is PROM bit 0 and green is PROM bit 1. Blue is PROM bit 2 AND PROM bit 3 (the kill bit). PROM bits 7:4 are ignored.
- R9: Red, green and blue are 0 whenever `de` is low.
- R10: `vblank_nmi` is high for exactly one clock per frame, for the counter state x=0, y=256.
- R11: `hsync` is high for x in [HS_BEG, HS_BEG+HS_LEN). `vsync` is high for y in [VS_BEG, VS_BEG+VS_LEN).
- R12: Pixels of adjacent cells follow one another without any gap or repeated pixel, including across line ends.
- R13: During reset all outputs are 0. The counter restarts at the last position of the frame, so pixel (0,0) appears on the outputs in the second clock after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_we | input | 1 | Host write strobe |
| cpu_addr | input | 16 | Host write address |
| cpu_wdata | input | 8 | Host write data |
| gfx_addr | output | 13 | Graphics row address {bank, code[8:0], row[2:0]} |
| gfx_data | input | 24 | Three plane bytes for gfx_addr, same cycle |
| pal_addr | output | 8 | Colour PROM address |
| pal_data | input | 8 | Colour PROM entry for pal_addr, same cycle |
| red | output | 1 | Red output |
| green | output | 1 | Green output |
| blue | output | 1 | Blue output after the kill gate |
| de | output | 1 | Display enable (visible area) |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| vblank_nmi | output | 1 | One-cycle start-of-blanking pulse |

## Verification
Each of two whole frames is compared pixel by pixel with a model that computes the cell, the graphics row, the plane bits and the PROM entry on its own. Any fetch that comes one cycle late or early shows up as every cell boundary repeating or dropping a pixel, and reversed plane order or bit order gives wrong colours almost everywhere. Directed cells cover the tile-code MSB, bank 1, the last cell index and ignored attribute bits 7:6: a cell differing from its twin only in those bits must look the same. Writes just outside both RAM windows, and at aliases that a partial decode would accept, would corrupt cell 0 or 1023 if they were decoded. A blue output that skips the kill gate fails on the many PROM entries whose kill bit is clear.

// File: rtl/tvg_pkg.sv
package tvg_pkg;

    localparam int TILE_PX  = 8;
    localparam int TILE_SH  = 3;
    localparam int COLOR_W  = 4;
    localparam int PIX_W    = 3;
    localparam int PAL_W    = 8;
    localparam int CODE_W   = 9;
    localparam int GFX_AW   = 1 + CODE_W + TILE_SH;

    // attribute byte layout: spare bits on top, colour group, bank, code MSB
    typedef struct packed {
        logic [1:0]         spare;
        logic [COLOR_W-1:0] color;
        logic               bank;
        logic               code_hi;
    } tile_attr_t;

    // hi plane feeds pixel bit 2, lo plane feeds pixel bit 0
    typedef struct packed {
        logic [TILE_PX-1:0] hi;
        logic [TILE_PX-1:0] mid;
        logic [TILE_PX-1:0] lo;
    } plane_set_t;

    typedef struct packed {
        logic r;
        logic g;
        logic b;
    } rgb_t;

    typedef struct packed {
        logic active;
        logic hsync;
        logic vsync;
        logic vbl;
    } beam_t;

    function automatic logic [PAL_W-1:0] pal_index(input logic [COLOR_W-1:0] color,
                                                   input logic [PIX_W-1:0]   pix);
        return {1'b0, color, pix};
    endfunction

    function automatic rgb_t pal_decode(input logic [PAL_W-1:0] entry);
        rgb_t c;
        c.r = entry[0];
        c.g = entry[1];
        c.b = entry[2] & entry[3];
        return c;
    endfunction

endpackage

// File: rtl/tvg_timing.sv
module tvg_timing
    import tvg_pkg::*;
#(
    parameter int H_TOTAL = 320,
    parameter int V_TOTAL = 264,
    parameter int ACT_W   = 256,
    parameter int ACT_H   = 256,
    parameter int HS_BEG  = 272,
    parameter int HS_LEN  = 24,
    parameter int VS_BEG  = 258,
    parameter int VS_LEN  = 3,
    parameter int COLS    = 32,
    parameter int IDX_W   = 10
) (
    input  logic             clk,
    input  logic             rst,
    output beam_t            beam,
    output logic             fetch_en,
    output logic [IDX_W-1:0] fetch_idx,
    output logic [TILE_SH-1:0] fetch_row
);

    localparam int HW = $clog2(H_TOTAL);
    localparam int VW = $clog2(V_TOTAL);
    localparam logic [HW-1:0] H_LAST  = HW'(H_TOTAL - 1);
    localparam logic [HW-1:0] ACT_W_C = HW'(ACT_W);
    localparam logic [HW-1:0] HS_B    = HW'(HS_BEG);
    localparam logic [HW-1:0] HS_E    = HW'(HS_BEG + HS_LEN);
    localparam logic [VW-1:0] V_LAST  = VW'(V_TOTAL - 1);
    localparam logic [VW-1:0] ACT_H_C = VW'(ACT_H);
    localparam logic [VW-1:0] VS_B    = VW'(VS_BEG);
    localparam logic [VW-1:0] VS_E    = VW'(VS_BEG + VS_LEN);

    logic [HW-1:0] hcnt, nx;
    logic [VW-1:0] vcnt, ny;
    logic          h_wrap;

    // next beam position; also the position whose cell gets prefetched
    always_comb begin
        h_wrap = (hcnt == H_LAST);
        nx     = h_wrap ? '0 : hcnt + HW'(1);
        if (h_wrap)
            ny = (vcnt == V_LAST) ? '0 : vcnt + VW'(1);
        else
            ny = vcnt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hcnt <= H_LAST;
            vcnt <= V_LAST;
        end else begin
            hcnt <= nx;
            vcnt <= ny;
        end
    end

    always_comb begin
        beam.active = (hcnt < ACT_W_C) && (vcnt < ACT_H_C);
        beam.hsync  = (hcnt >= HS_B) && (hcnt < HS_E);
        beam.vsync  = (vcnt >= VS_B) && (vcnt < VS_E);
        beam.vbl    = (hcnt == '0) && (vcnt == ACT_H_C);
        fetch_en    = (nx < ACT_W_C) && (nx[TILE_SH-1:0] == '0) && (ny < ACT_H_C);
        fetch_row   = ny[TILE_SH-1:0];
        fetch_idx   = IDX_W'(((32'(ny) >> TILE_SH) * 32'(COLS)) + (32'(nx) >> TILE_SH));
    end

    // R1: beam position never leaves the frame
    p_pos_range_r1: assert property (@(posedge clk) disable iff (rst)
        (hcnt <= H_LAST) && (vcnt <= V_LAST));

    // R10: start-of-blanking strobe lasts a single cycle
    p_vbl_single_r10: assert property (@(posedge clk) disable iff (rst)
        beam.vbl |=> !beam.vbl);

endmodule

// File: rtl/tvg_tile_ram.sv
module tvg_tile_ram #(
    parameter int              ADDR_W = 16,
    parameter int              DEPTH  = 1024,
    parameter logic [ADDR_W-1:0] BASE = 16'h1000,
    localparam int             AW     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic [AW-1:0]     rd_idx,
    output logic [7:0]        rd_data,
    output logic              hit
);

    localparam logic [ADDR_W-AW-1:0] TAG = BASE[ADDR_W-1:AW];

    logic [7:0] mem [DEPTH];

    assign hit     = we && (addr[ADDR_W-1:AW] == TAG);
    assign rd_data = mem[rd_idx];

    // storage carries no reset so the host may load it while the raster is held
    always_ff @(posedge clk) begin
        if (hit)
            mem[addr[AW-1:0]] <= wdata;
    end

endmodule

// File: rtl/tvg_shifter.sv
module tvg_shifter
    import tvg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  plane_set_t         planes,
    input  logic [COLOR_W-1:0] color_in,
    output logic [PIX_W-1:0]   pix,
    output logic [COLOR_W-1:0] color
);

    plane_set_t sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh    <= '0;
            color <= '0;
        end else if (load) begin
            sh    <= planes;
            color <= color_in;
        end else begin
            sh.hi  <= sh.hi  << 1;
            sh.mid <= sh.mid << 1;
            sh.lo  <= sh.lo  << 1;
        end
    end

    assign pix = {sh.hi[TILE_PX-1], sh.mid[TILE_PX-1], sh.lo[TILE_PX-1]};

    // R12: loads are spaced by a full cell, never on consecutive cycles
    p_load_spacing_r12: assert property (@(posedge clk) disable iff (rst)
        load |=> !load);

endmodule

// File: rtl/tvg_pixel_out.sv
module tvg_pixel_out
    import tvg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  beam_t            beam_in,
    input  logic [PAL_W-1:0] pal_entry,
    output logic             red,
    output logic             green,
    output logic             blue,
    output logic             de,
    output logic             hsync,
    output logic             vsync,
    output logic             vbl
);

    rgb_t lut;

    assign lut = pal_decode(pal_entry);

    always_ff @(posedge clk) begin
        if (rst) begin
            red <= 1'b0; green <= 1'b0; blue <= 1'b0;
            de  <= 1'b0; hsync <= 1'b0; vsync <= 1'b0; vbl <= 1'b0;
        end else begin
            red   <= beam_in.active & lut.r;
            green <= beam_in.active & lut.g;
            blue  <= beam_in.active & lut.b;
            de    <= beam_in.active;
            hsync <= beam_in.hsync;
            vsync <= beam_in.vsync;
            vbl   <= beam_in.vbl;
        end
    end

    // R9: no colour outside the visible area
    p_dark_blank_r9: assert property (@(posedge clk) disable iff (rst)
        !de |-> !(red || green || blue));

    // R8: blue only from an entry whose kill bit was set
    p_blue_kill_r8: assert property (@(posedge clk) disable iff (rst)
        blue |-> $past(pal_entry[3]));

endmodule

// File: rtl/tile_video_gen.sv
module tile_video_gen
    import tvg_pkg::*;
#(
    parameter int          H_TOTAL   = 320,
    parameter int          V_TOTAL   = 264,
    parameter int          HS_BEG    = 272,
    parameter int          HS_LEN    = 24,
    parameter int          VS_BEG    = 258,
    parameter int          VS_LEN    = 3,
    parameter int          COLS      = 32,
    parameter int          ROWS      = 32,
    parameter logic [15:0] CODE_BASE = 16'h1000,
    parameter logic [15:0] ATTR_BASE = 16'h1800
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cpu_we,
    input  logic [15:0]   cpu_addr,
    input  logic [7:0]    cpu_wdata,
    output logic [12:0]   gfx_addr,
    input  logic [23:0]   gfx_data,
    output logic [7:0]    pal_addr,
    input  logic [7:0]    pal_data,
    output logic          red,
    output logic          green,
    output logic          blue,
    output logic          de,
    output logic          hsync,
    output logic          vsync,
    output logic          vblank_nmi
);

    localparam int CELLS = COLS * ROWS;
    localparam int IDX_W = $clog2(CELLS);
    localparam int ACT_W = COLS * TILE_PX;
    localparam int ACT_H = ROWS * TILE_PX;
    localparam int NRAM  = 2;

    beam_t              beam;
    logic               fetch_en;
    logic [IDX_W-1:0]   fetch_idx;
    logic [TILE_SH-1:0] fetch_row;
    logic [7:0]         ram_q [NRAM];
    logic [NRAM-1:0]    ram_hit;
    tile_attr_t         attr;
    logic [PIX_W-1:0]   pix;
    logic [COLOR_W-1:0] pix_color;

    tvg_timing #(
        .H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL),
        .ACT_W(ACT_W), .ACT_H(ACT_H),
        .HS_BEG(HS_BEG), .HS_LEN(HS_LEN),
        .VS_BEG(VS_BEG), .VS_LEN(VS_LEN),
        .COLS(COLS), .IDX_W(IDX_W)
    ) u_timing (
        .clk(clk), .rst(rst), .beam(beam),
        .fetch_en(fetch_en), .fetch_idx(fetch_idx), .fetch_row(fetch_row)
    );

    // entry 0 holds tile codes, entry 1 holds attributes
    for (genvar g = 0; g < NRAM; g++) begin : g_ram
        tvg_tile_ram #(
            .ADDR_W(16), .DEPTH(CELLS),
            .BASE((g == 0) ? CODE_BASE : ATTR_BASE)
        ) u_ram (
            .clk(clk), .we(cpu_we), .addr(cpu_addr), .wdata(cpu_wdata),
            .rd_idx(fetch_idx), .rd_data(ram_q[g]), .hit(ram_hit[g])
        );
    end

    assign attr     = tile_attr_t'(ram_q[1]);
    assign gfx_addr = {attr.bank, attr.code_hi, ram_q[0], fetch_row};

    tvg_shifter u_shift (
        .clk(clk), .rst(rst), .load(fetch_en),
        .planes(plane_set_t'(gfx_data)), .color_in(attr.color),
        .pix(pix), .color(pix_color)
    );

    assign pal_addr = pal_index(pix_color, pix);

    tvg_pixel_out u_out (
        .clk(clk), .rst(rst), .beam_in(beam), .pal_entry(pal_data),
        .red(red), .green(green), .blue(blue), .de(de),
        .hsync(hsync), .vsync(vsync), .vbl(vblank_nmi)
    );

    // R2: the two RAM windows never claim the same host write
    p_ram_exclusive_r2: assert property (@(posedge clk) disable iff (rst)
        !(ram_hit[0] && ram_hit[1]));

    // R7: the upper half of the colour PROM is never addressed
    p_pal_lower_r7: assert property (@(posedge clk) disable iff (rst)
        !pal_addr[7]);

endmodule

// File: tb/test_tile_video_gen.sv
module test_tile_video_gen;

    localparam int H     = 272;
    localparam int V     = 262;
    localparam int AW    = 256;
    localparam int AH    = 256;
    localparam int HSB   = 260;
    localparam int HSL   = 8;
    localparam int VSB   = 257;
    localparam int VSL   = 2;
    localparam int FRAME = H * V;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic        cpu_we = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic [12:0] gfx_addr;
    logic [23:0] gfx_data;
    logic [7:0]  pal_addr, pal_data;
    logic        red, green, blue, de, hsync, vsync, vblank_nmi;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [7:0] sh_code [1024];
    logic [7:0] sh_attr [1024];

    function automatic logic [7:0] gfx_byte(logic [12:0] a, int p);
        int v;
        v = (int'(a) + 1) * (2 * p + 5) * 193 + p * 71;
        return 8'(v ^ (v >> 9));
    endfunction

    function automatic logic [23:0] gfx_word(logic [12:0] a);
        return {gfx_byte(a, 0), gfx_byte(a, 1), gfx_byte(a, 2)};
    endfunction

    function automatic logic [7:0] prom(logic [7:0] i);
        int v;
        v = int'(i) * 113 + 29;
        return 8'(v ^ (v >> 7));
    endfunction

    assign gfx_data = gfx_word(gfx_addr);
    assign pal_data = prom(pal_addr);

    tile_video_gen #(
        .H_TOTAL(H), .V_TOTAL(V), .HS_BEG(HSB), .HS_LEN(HSL),
        .VS_BEG(VSB), .VS_LEN(VSL)
    ) i_tile_video_gen (
        .clk(clk), .rst(rst), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .gfx_addr(gfx_addr), .gfx_data(gfx_data),
        .pal_addr(pal_addr), .pal_data(pal_data), .red(red), .green(green),
        .blue(blue), .de(de), .hsync(hsync), .vsync(vsync),
        .vblank_nmi(vblank_nmi)
    );

    // expected {de,hsync,vsync,vblank} for output cycle p (R1, R10, R11)
    function automatic logic [3:0] exp_beam(int p);
        int q, x, y;
        q = (p + FRAME) % FRAME;
        x = q % H;
        y = q / H;
        return {(x < AW) && (y < AH), (x >= HSB) && (x < HSB + HSL),
                (y >= VSB) && (y < VSB + VSL), (x == 0) && (y == AH)};
    endfunction

    // expected {r,g,b} (R3 R4 R5 R6 R7 R8 R9)
    function automatic logic [2:0] exp_rgb(int p);
        int q, x, y, idx, k;
        logic [7:0]  a, e;
        logic [23:0] w;
        logic [2:0]  pix;
        q = (p + FRAME) % FRAME;
        x = q % H;
        y = q / H;
        if (x >= AW || y >= AH) return 3'b000;
        idx = (y / 8) * 32 + x / 8;
        a   = sh_attr[idx];
        w   = gfx_word({a[1], a[0], sh_code[idx], 3'(y % 8)});
        k   = x % 8;
        pix = {w[23 - k], w[15 - k], w[7 - k]};
        e   = prom({1'b0, a[5:2], pix});
        return {e[0], e[1], e[2] & e[3]};
    endfunction

    task automatic check(string req, int t, logic [6:0] act, logic [6:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s cycle %0d: got %b expected %b", req, t, act, exp);
        end
    endtask

    task automatic cpu_wr(logic [15:0] a, logic [7:0] d);
        @(negedge clk);
        cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_we = 1'b0;
        // R2: shadow only the two valid windows
        if (a >= 16'h1000 && a < 16'h1400) sh_code[int'(a) - 32'h1000] = d;
        else if (a >= 16'h1800 && a < 16'h1C00) sh_attr[int'(a) - 32'h1800] = d;
    endtask

    task automatic fill_random();
        for (int i = 0; i < 1024; i++) begin
            cpu_wr(16'h1000 + 16'(i), 8'($urandom));
            cpu_wr(16'h1800 + 16'(i), 8'($urandom));
        end
    endtask

    task automatic run_frame(string rgb_tag);
        for (int t = 0; t < FRAME + 2; t++) begin
            @(negedge clk);
            check("R1/R10/R11 beam", t, {3'b000, de, hsync, vsync, vblank_nmi},
                  {3'b000, exp_beam(t - 1)});
            check((t < 2) ? "R13 first pixel" : rgb_tag, t,
                  {4'b0000, red, green, blue}, {4'b0000, exp_rgb(t - 1)});
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20251));
        for (int i = 0; i < 1024; i++) begin
            sh_code[i] = '0;
            sh_attr[i] = '0;
        end
        repeat (3) @(negedge clk);
        // R13: reset state
        check("R13 reset", 0, {red, green, blue, de, hsync, vsync, vblank_nmi}, 7'b0);

        // pass 1: random screen contents
        fill_random();
        @(negedge clk);
        rst = 1'b0;
        run_frame("R3/R4/R6/R7/R8/R9/R12 random");

        // pass 2: directed corner cells plus ignored writes
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        fill_random();
        cpu_wr(16'h1000, 8'hA5); cpu_wr(16'h1800, 8'hFF);   // R5 spare bits set, bank1, MSB
        cpu_wr(16'h1001, 8'hA5); cpu_wr(16'h1801, 8'h3F);   // R5 twin without spare bits
        cpu_wr(16'h1002, 8'hFF); cpu_wr(16'h1802, 8'h01);   // R3 code 511 bank 0
        cpu_wr(16'h13FF, 8'h00); cpu_wr(16'h1BFF, 8'h3E);   // R4 last cell, bank 1
        cpu_wr(16'h1400, 8'h5A); cpu_wr(16'h0FFF, 8'hC3);   // R2 outside code window
        cpu_wr(16'h1C00, 8'h81); cpu_wr(16'h17FF, 8'h7E);   // R2 outside attr window
        cpu_wr(16'h5000, 8'h99); cpu_wr(16'h5BFF, 8'h66);   // R2 partial-decode aliases
        @(negedge clk);
        rst = 1'b0;
        run_frame("R2/R3/R4/R5/R6/R8/R12 directed");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule